// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block collects interrupt requests for a small CPU: eight external pins, a set of level requests from internal peripherals, and a software trap. Each external pin is synchronised and watched for one fixed edge type. A detected edge is held in a pending latch until the CPU acknowledges it. Pending external events pass only when their enable bit is set. All maskable requests are then gated by a global mask bit. One request is chosen by fixed priority and is presented to the CPU as a vector index with a valid flag.

The CPU takes a request only at an instruction boundary, which it marks with an end-of-instruction strobe. When the controller accepts a request it sets the global mask bit, so a running handler cannot be pre-empted by another maskable source. A return-from-interrupt strobe clears the mask bit again. The CPU can also load the mask bit directly. Two wake outputs tell the power controller when the device may leave its light or its deep sleep mode. Neither wake output depends on the mask bit.

Top module: `irqc_top`

## Requirements
- R1: External inputs 1, 2, 5 and 6 (pin bits 0, 1, 4, 5) become pending on a low-to-high transition. A high-to-low transition on them has no effect.
- R2: External inputs 3, 4, 7 and 8 (pin bits 2, 3, 6, 7) become pending on a high-to-low transition. A low-to-high transition on them has no effect.
- R3: A pending external event is forwarded only while its bit in `ext_en` is 1. An event that is latched while its enable bit is 0 is kept, and it is serviced once the enable bit is set.
- R4: While `global_mask` is 1, no external or peripheral request is accepted. Such a request stays pending and is accepted after the mask is cleared.
- R5: Acceptance happens only in a cycle with `instr_end` high and `irq_valid` low. `irq_valid` and `irq_vec` update on the next clock edge. With no strobe, nothing is accepted.
- R6: Accepting any request sets `global_mask` to 1 on the same edge that raises `irq_valid`.
- R7: `global_mask` is 1 after reset. `iret` clears it on the next edge. `mask_load` writes `mask_val` into it. Acceptance takes precedence over `iret`, and `iret` takes precedence over `mask_load`.
- R8: Vector encoding: 0 is the trap, 1 to 8 are external inputs 1 to 8, and 9 upward are peripheral requests 0 upward. When several requests qualify at once, the smallest vector number wins. `irq_vec` holds steady while `irq_valid` is high.
- R9: A `trap_req` pulse makes the trap pending. The trap is accepted whatever the value of `global_mask`.
- R10: `ack` while `irq_valid` is high clears `irq_valid` and the pending latch of the presented source on the next edge.
- R11: `wake_light` is high whenever the trap is pending, any peripheral request is high, or any enabled external event is pending. This holds regardless of `global_mask`.
- R12: `wake_deep` is high only for enabled pending external events and for peripheral requests marked halt-capable (default: peripheral 1 only). A pending trap and other peripherals do not raise it.
- R13: After reset, `irq_valid` is 0, `irq_vec` is 0, and both wake outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 8 | Asynchronous external interrupt pins |
| ext_en | input | 8 | Per-pin enable bits |
| per_req | input | 3 | Level requests from internal peripherals |
| trap_req | input | 1 | Software trap pulse |
| instr_end | input | 1 | End-of-instruction strobe |
| ack | input | 1 | CPU has taken the presented vector |
| iret | input | 1 | Return-from-interrupt strobe |
| mask_load | input | 1 | Load strobe for the global mask bit |
| mask_val | input | 1 | Value written by `mask_load` |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 4 | Presented vector index |
| global_mask | output | 1 | Global interrupt mask bit |
| wake_light | output | 1 | Wake request for light sleep |
| wake_deep | output | 1 | Wake request for deep sleep |

## Verification
A corrupt pending latch shows up on `wake_light` within one cycle, since that output is derived directly from the latches. The same fault reaches `irq_vec` at the next instruction boundary. A wrong edge polarity or a broken synchroniser appears as a missing or extra wake exactly three edges after the pin change. A wrong mask or priority state appears as a wrong vector, or an unexpected `irq_valid`, one edge after the strobe. The reference model compares every port on every cycle, so the first bad cycle is reported.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Index of the lowest set bit. Returns -1 when no bit is set.
  function automatic int lowest_set(input logic [31:0] req, input int width);
    int idx;
    idx = -1;
    for (int b = width - 1; b >= 0; b--) begin
      if (req[b]) idx = b;
    end
    return idx;
  endfunction

  // Edge of the requested polarity between the previous and current samples.
  function automatic logic edge_seen(input logic cur, input logic prev, input logic falling);
    return falling ? (prev & ~cur) : (cur & ~prev);
  endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int          N         = 8,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] evt
);
  import irqc_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic meta_q, sync_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= pin[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end
    assign evt[i] = edge_seen(sync_q, last_q, FALL_MASK[i]);
  end

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ext_set,
  input  logic [N-1:0] ext_clr,
  input  logic         trap_set,
  input  logic         trap_clr,
  output logic [N-1:0] ext_pend,
  output logic         trap_pend
);

  // A new event in the same cycle as a clear wins, so it is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_pend  <= '0;
      trap_pend <= 1'b0;
    end else begin
      ext_pend  <= (ext_pend & ~ext_clr) | ext_set;
      trap_pend <= (trap_pend & ~trap_clr) | trap_set;
    end
  end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N_SRC = 12,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] cand,
  input  logic             instr_end,
  input  logic             ack,
  output logic             accept,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec
);
  import irqc_pkg::*;

  logic [31:0]      cand_w;
  logic [VEC_W-1:0] winner;

  assign cand_w = 32'(cand);
  assign winner = VEC_W'(lowest_set(cand_w, N_SRC));
  assign accept = instr_end & ~irq_valid & (|cand);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
    end else if (accept) begin
      irq_valid <= 1'b1;
      irq_vec   <= winner;
    end else if (ack) begin
      irq_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int            N_EXT     = 8,
  parameter int            N_PER     = 3,
  parameter logic [N_EXT-1:0] EXT_FALL = 8'b1100_1100,
  parameter logic [N_PER-1:0] PER_HALT = 3'b010,
  localparam int           N_SRC     = 1 + N_EXT + N_PER,
  localparam int           VEC_W     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_PER-1:0] per_req,
  input  logic             trap_req,
  input  logic             instr_end,
  input  logic             ack,
  input  logic             iret,
  input  logic             mask_load,
  input  logic             mask_val,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec,
  output logic             global_mask,
  output logic             wake_light,
  output logic             wake_deep
);

  logic [N_EXT-1:0] ext_evt, ext_pend, ext_clr, ext_live;
  logic             trap_pend, trap_clr, accept, taken;
  logic [N_SRC-1:0] cand, clr_onehot;

  irqc_edge #(.N(N_EXT), .FALL_MASK(EXT_FALL)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .evt(ext_evt)
  );

  irqc_pend #(.N(N_EXT)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .ext_set(ext_evt), .ext_clr(ext_clr),
    .trap_set(trap_req), .trap_clr(trap_clr),
    .ext_pend(ext_pend), .trap_pend(trap_pend)
  );

  assign ext_live = ext_pend & ext_en;

  // Source order: trap, external pins, peripherals.
  assign cand[0] = trap_pend;
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext_cand
    assign cand[1 + i] = ext_live[i] & ~global_mask;
  end
  for (genvar j = 0; j < N_PER; j++) begin : g_per_cand
    assign cand[1 + N_EXT + j] = per_req[j] & ~global_mask;
  end

  irqc_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand), .instr_end(instr_end), .ack(ack),
    .accept(accept), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // Clear the latch of the source being acknowledged.
  assign taken = ack & irq_valid;
  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    assign clr_onehot[s] = taken & (irq_vec == VEC_W'(s));
  end
  assign trap_clr = clr_onehot[0];
  assign ext_clr  = clr_onehot[N_EXT:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         global_mask <= 1'b1;
    else if (accept)    global_mask <= 1'b1;
    else if (iret)      global_mask <= 1'b0;
    else if (mask_load) global_mask <= mask_val;
  end

  assign wake_light = trap_pend | (|ext_live) | (|per_req);
  assign wake_deep  = (|ext_live) | (|(per_req & PER_HALT));

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_end,
  input logic             ack,
  input logic             iret,
  input logic             accept,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic             global_mask,
  input logic             wake_light,
  input logic             wake_deep
);

  p_accept_sets_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (global_mask && irq_valid));

  p_boundary_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(instr_end));

  p_masked_only_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && $past(global_mask)) |-> (irq_vec == '0));

  p_iret_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !accept) |=> !global_mask);

  p_ack_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> !irq_valid);

  p_vec_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_vec)));

  p_deep_in_light_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_deep |-> wake_light);

endmodule

bind irqc_top irqc_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .ack(ack), .iret(iret),
  .accept(accept), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .global_mask(global_mask), .wake_light(wake_light), .wake_deep(wake_deep)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ext_pin = 8'b1100_1100;
  logic [7:0] ext_en = '0;
  logic [2:0] per_req = '0;
  logic       trap_req = 0, instr_end = 0, ack = 0, iret = 0, mask_load = 0, mask_val = 0;
  logic       irq_valid, global_mask, wake_light, wake_deep;
  logic [3:0] irq_vec;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_en(ext_en), .per_req(per_req),
    .trap_req(trap_req), .instr_end(instr_end), .ack(ack), .iret(iret),
    .mask_load(mask_load), .mask_val(mask_val), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .global_mask(global_mask), .wake_light(wake_light), .wake_deep(wake_deep)
  );

  // Behavioural reference model.
  bit m_pend[8];
  bit m_trap, m_valid, m_mask;
  int m_vec;
  logic [7:0] pin_hist[$];   // pin samples, newest at the back

  function automatic bit is_falling(int n);  // n is the input number, 1..8
    return (n == 3) || (n == 4) || (n == 7) || (n == 8);
  endfunction

  function automatic bit m_wake_light();
    bit w = m_trap || (per_req != 0);
    foreach (m_pend[i]) if (m_pend[i] && ext_en[i]) w = 1;
    return w;
  endfunction

  function automatic bit m_wake_deep();
    bit w = per_req[1];
    foreach (m_pend[i]) if (m_pend[i] && ext_en[i]) w = 1;
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_pend[i]) m_pend[i] = 0;
    m_trap = 0; m_valid = 0; m_mask = 1; m_vec = 0;
    pin_hist.delete();
    repeat (3) pin_hist.push_back(8'h00);
  endtask

  // State after the coming rising edge, with the inputs as currently driven.
  task automatic model_next();
    logic [7:0] newer, older;
    int best;
    bit acc;
    bit n_pend[8];
    bit n_trap;
    newer = pin_hist[1];
    older = pin_hist[0];
    best = -1;
    if (m_trap) best = 0;
    for (int i = 0; i < 8 && best < 0; i++)
      if (!m_mask && m_pend[i] && ext_en[i]) best = i + 1;
    for (int j = 0; j < 3 && best < 0; j++)
      if (!m_mask && per_req[j]) best = 9 + j;
    acc = instr_end && !m_valid && (best >= 0);
    n_trap = (m_trap && !(m_valid && ack && m_vec == 0)) || trap_req;
    for (int i = 0; i < 8; i++) begin
      bit ev = is_falling(i + 1) ? (older[i] && !newer[i]) : (!older[i] && newer[i]);
      n_pend[i] = (m_pend[i] && !(m_valid && ack && m_vec == i + 1)) || ev;
    end
    if (acc) m_mask = 1;
    else if (iret) m_mask = 0;
    else if (mask_load) m_mask = mask_val;
    if (acc) begin m_valid = 1; m_vec = best; end
    else if (ack) m_valid = 0;
    m_trap = n_trap;
    foreach (m_pend[i]) m_pend[i] = n_pend[i];
    void'(pin_hist.pop_front());
    pin_hist.push_back(ext_pin);
  endtask

  task automatic compare_all();
    check("R5 irq_valid", irq_valid, m_valid);
    check("R8 irq_vec", irq_vec, m_vec);
    check("R7 global_mask", global_mask, m_mask);
    check("R11 wake_light", wake_light, m_wake_light());
    check("R12 wake_deep", wake_deep, m_wake_deep());
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      model_next();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_end();  instr_end = 1; cyc(); instr_end = 0; endtask
  task automatic pulse_ack();  ack = 1; cyc(); ack = 0; endtask
  task automatic pulse_iret(); iret = 1; cyc(); iret = 0; endtask
  task automatic load_mask(bit v); mask_load = 1; mask_val = v; cyc(); mask_load = 0; endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 valid", irq_valid, 0);
    check("R13 vec", irq_vec, 0);
    check("R7 mask at reset", global_mask, 1);
    check("R13 wake_light", wake_light, 0);
    check("R13 wake_deep", wake_deep, 0);
    rst_n = 1;
    // The synchroniser resets low, so the idle-high falling pins rise once after reset.
    cyc(4);

    ext_en = 8'hFF;
    load_mask(0);
    check("R7 mask_load", global_mask, 0);

    // R1: rising edge on input 1 is taken, falling edge on it is not.
    ext_pin[0] = 1; cyc(4);
    check("R1 rising pending", wake_light, 1);
    check("R12 ext wakes deep", wake_deep, 1);
    pulse_end();
    check("R5 accepted", irq_valid, 1);
    check("R8 vec input1", irq_vec, 1);
    check("R6 mask set", global_mask, 1);
    pulse_ack();
    check("R10 valid drop", irq_valid, 0);
    check("R10 pending cleared", wake_light, 0);
    pulse_iret();
    check("R7 iret clears", global_mask, 0);
    ext_pin[0] = 0; cyc(4);
    check("R1 falling ignored", wake_light, 0);

    // R2: falling edge on input 3 is taken, rising edge on it is not.
    ext_pin[2] = 0; cyc(4);
    check("R2 falling pending", wake_light, 1);
    pulse_end();
    check("R2 vec input3", irq_vec, 3);
    pulse_ack(); pulse_iret();
    ext_pin[2] = 1; cyc(4);
    check("R2 rising ignored", wake_light, 0);

    // R3: event kept while disabled, serviced when enabled.
    ext_en[3] = 0;
    ext_pin[3] = 0; cyc(4);
    check("R3 disabled no wake", wake_light, 0);
    pulse_end();
    check("R3 disabled not accepted", irq_valid, 0);
    ext_en[3] = 1; cyc();
    check("R3 enabled wake", wake_light, 1);
    pulse_end();
    check("R3 vec input4", irq_vec, 4);
    pulse_ack(); pulse_iret();
    ext_pin[3] = 1;

    // R5: pending and unmasked but no boundary strobe.
    ext_pin[4] = 1; cyc(8);
    check("R5 no strobe", irq_valid, 0);
    pulse_end();
    check("R5 vec input5", irq_vec, 5);
    pulse_ack(); pulse_iret();

    // R4: masked request held and taken after unmasking.
    load_mask(1);
    ext_pin[5] = 1; cyc(4);
    pulse_end();
    check("R4 masked not taken", irq_valid, 0);
    check("R11 wake while masked", wake_light, 1);
    load_mask(0);
    pulse_end();
    check("R4 taken after unmask", irq_vec, 6);
    pulse_ack(); pulse_iret();

    // R8: several at once, lowest number first.
    ext_pin[6] = 0; ext_pin[1] = 1; per_req[0] = 1; cyc(4);
    pulse_end();
    check("R8 first vec2", irq_vec, 2);
    pulse_ack(); pulse_iret();
    pulse_end();
    check("R8 second vec7", irq_vec, 7);
    pulse_ack(); pulse_iret();
    pulse_end();
    check("R8 third vec9", irq_vec, 9);
    per_req[0] = 0;
    pulse_ack(); pulse_iret();

    // R9: trap taken while masked; R12 trap does not wake deep sleep.
    load_mask(1);
    trap_req = 1; cyc(); trap_req = 0; cyc();
    check("R11 trap wake_light", wake_light, 1);
    check("R12 trap no deep", wake_deep, 0);
    pulse_end();
    check("R9 trap accepted masked", irq_valid, 1);
    check("R9 trap vec", irq_vec, 0);
    pulse_ack();
    check("R10 trap cleared", wake_light, 0);

    // R12: only halt-capable peripheral raises deep wake.
    per_req = 3'b001; cyc();
    check("R11 periph light", wake_light, 1);
    check("R12 periph0 no deep", wake_deep, 0);
    per_req = 3'b010; cyc();
    check("R12 periph1 deep", wake_deep, 1);
    per_req = 3'b100; cyc();
    check("R12 periph2 no deep", wake_deep, 0);
    // R7: acceptance wins over iret in the same cycle.
    load_mask(0);
    instr_end = 1; iret = 1; cyc(); instr_end = 0; iret = 0;
    check("R7 accept over iret", global_mask, 1);
    check("R8 vec11", irq_vec, 11);
    per_req = 0;
    pulse_ack(); pulse_iret();
    cyc(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule